// File: doc/BRIEF.md
# Serial Converter Read Master

This block is the host side of a single read from a 10-bit successive-approximation converter that talks over a clocked, half-duplex serial link. A one-cycle start request carries the channel and mode settings. The block then pulls chip select low and generates the serial clock by dividing the system clock. It shifts out a framed configuration word, throws away the one null bit the converter sends back, and gathers the 10 result bits in whichever order was requested. At the end it raises chip select and hands over the value with a one-cycle done strobe.

Three kinds of converter are handled, selected per transfer:
- a short-word part, with three configuration bits;
- a long-word part, with six configuration bits;
- a fixed part, which takes no configuration word and always answers MSB first.

The outgoing data pin has its own output enable. Board logic can therefore join it to the incoming pin, so that one wire serves both directions. The enable is released before the converter starts driving the line.

Top module: `adc_read_master`

## Requirements
- R1: A start request taken while idle pulls `cs_n` low on the next system-clock edge and sets `busy`. `cs_n` goes high again, and `busy` clears, on the same edge that raises `done`.
- R2: While `cs_n` is low, `sclk` stays high for `half_div` system cycles and low for `half_div` system cycles, with a `half_div` of 0 treated as 1. The first rising edge comes `half_div` cycles after `cs_n` falls. While `cs_n` is high, `sclk` is low. A transfer of F serial clocks lasts 2·half_div·F system cycles from the fall of `cs_n` to `done`.
- R3: `mosi` changes only on falling `sclk` edges or at the fall of `cs_n`. The first bit driven is a start bit of 1, present from the moment `cs_n` falls.
- R4: When `fmt` is 2'b01, four bits go out in this order: 1, `sgl_end`, `odd_sign`, `msb_first`.
- R5: When `fmt[1]` is 1, seven bits go out in this order: 1, `sgl_end`, `odd_sign`, `chan_sel[1]`, `chan_sel[0]`, `unipolar`, `msb_first`.
- R6: When `fmt` is 2'b00 (fixed part), nothing is sent and `mosi_oe` stays low. One clock wakes the part, one null bit follows, and the result is always taken MSB first, whatever `msb_first` says.
- R7: `mosi_oe` is high from the fall of `cs_n` while configuration bits are being sent. It drops on the falling edge that follows the last configuration bit, so it is low before the null bit is sampled.
- R8: With L serial clocks used for configuration (L is 1 for the fixed part), the sample taken on rising edge L+1 is discarded. The samples on rising edges L+2 to L+11 form the result. The transfer ends on the falling edge after rising edge L+11.
- R9: When `msb_first` is 1, the first result sample lands in `result[9]`. When it is 0, the first result sample lands in `result[0]` and later samples fill upward.
- R10: `done` is high for exactly one system cycle. `result` holds its value until the next `done`.
- R11: A start request while `busy` is high has no effect. The transfer in progress keeps its settings and its result, and no extra transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle read request |
| fmt | input | 2 | Part kind: 00 fixed, 01 short word, 1x long word |
| sgl_end | input | 1 | Single-ended (1) or differential (0) input selection |
| odd_sign | input | 1 | Channel parity or polarity bit |
| chan_sel | input | 2 | Channel select bits (long word only) |
| unipolar | input | 1 | Unipolar range bit (long word only) |
| msb_first | input | 1 | Requested result bit order |
| half_div | input | DIV_W | Serial half-period in system cycles |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Outgoing serial data |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Incoming serial data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 10 | Assembled conversion value |

## Verification
The bench builds the block with DIV_W set to 3. This keeps every half-period setting from 0 to 7 cheap to run, so the zero clamp and the widest divider both appear among the random transfers. A converter model in the bench decodes the framed word on its own and answers in the order it decoded. This puts the three part kinds, both bit orders and the hand-over of the data line all within reach. A start request fired into a transfer that is already running tests that the request is ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int RES_W    = 10;
  localparam int WORD_MAX = 7;
  localparam int WIDX_W   = $clog2(WORD_MAX);
  localparam int IDX_W    = 5;

  typedef enum logic [1:0] {
    FMT_FIXED = 2'b00,
    FMT_SHORT = 2'b01,
    FMT_LONG  = 2'b10,
    FMT_LONG2 = 2'b11
  } fmt_e;

  // serial clocks in which the master drives configuration bits
  function automatic logic [IDX_W-1:0] drive_len(input logic [1:0] fmt);
    if (fmt == FMT_FIXED)      return IDX_W'(0);
    else if (fmt == FMT_SHORT) return IDX_W'(4);
    else                       return IDX_W'(WORD_MAX);
  endfunction

  // serial clocks before the null bit (fixed part spends one wake-up clock)
  function automatic logic [IDX_W-1:0] skip_len(input logic [1:0] fmt);
    if (fmt == FMT_FIXED) return IDX_W'(1);
    else                  return drive_len(fmt);
  endfunction

  // position 0 goes out first
  function automatic logic [WORD_MAX-1:0] build_word(
    input logic [1:0] fmt, input logic sgl, input logic odd,
    input logic [1:0] sel, input logic uni, input logic msbf);
    logic [WORD_MAX-1:0] w;
    w = '0;
    w[0] = 1'b1;
    if (fmt == FMT_SHORT) begin
      w[1] = sgl; w[2] = odd; w[3] = msbf;
    end else if (fmt[1]) begin
      w[1] = sgl; w[2] = odd; w[3] = sel[1]; w[4] = sel[0];
      w[5] = uni; w[6] = msbf;
    end
    return w;
  endfunction

  // put one arriving result bit into the accumulator
  function automatic logic [RES_W-1:0] place_bit(
    input logic [RES_W-1:0] acc, input logic b, input logic msbf);
    if (msbf) return {acc[RES_W-2:0], b};
    else      return {b, acc[RES_W-1:1]};
  endfunction
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             toggle;

  assign lim      = (half_div == '0) ? '0 : half_div - 1'b1;
  assign toggle   = run && (cnt == lim);
  assign rise_stb = toggle && !sclk;
  assign fall_stb = toggle && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (toggle) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= lim); // R2
endmodule

// File: rtl/adc_rd_tx.sv
module adc_rd_tx
  import adc_rd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORD_MAX-1:0] word,
  input  logic [IDX_W-1:0]    len,
  input  logic                fall_stb,
  input  logic [IDX_W-1:0]    fall_idx,
  output logic                mosi,
  output logic                mosi_oe
);
  logic [WORD_MAX-1:0] word_q;
  logic [IDX_W-1:0]    len_q;
  logic                shift_evt;

  assign shift_evt = fall_stb && mosi_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      len_q   <= '0;
      mosi    <= 1'b0;
      mosi_oe <= 1'b0;
    end else if (load) begin
      word_q  <= word;
      len_q   <= len;
      mosi    <= (len != '0) && word[0];
      mosi_oe <= (len != '0);
    end else if (shift_evt) begin
      if (fall_idx < len_q) begin
        mosi <= word_q[fall_idx[WIDX_W-1:0]];
      end else begin
        mosi    <= 1'b0;
        mosi_oe <= 1'b0;
      end
    end
  end

  AST_START_BIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mosi_oe) |-> mosi); // R3
endmodule

// File: rtl/adc_rd_rx.sv
module adc_rd_rx
  import adc_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rise_stb,
  input  logic [IDX_W-1:0] rise_num,
  input  logic [IDX_W-1:0] first_num,
  input  logic             msbf,
  input  logic             miso,
  output logic [RES_W-1:0] data
);
  logic [IDX_W-1:0] cap_cnt;
  logic             take;

  assign take = rise_stb && (rise_num >= first_num) &&
                (rise_num < first_num + IDX_W'(RES_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      cap_cnt <= '0;
    end else if (clear) begin
      data    <= '0;
      cap_cnt <= '0;
    end else if (take) begin
      data    <= place_bit(data, miso, msbf);
      cap_cnt <= cap_cnt + 1'b1;
    end
  end

  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cap_cnt <= IDX_W'(RES_W)); // R8
endmodule

// File: rtl/adc_read_master.sv
module adc_read_master
  import adc_rd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       fmt,
  input  logic             sgl_end,
  input  logic             odd_sign,
  input  logic [1:0]       chan_sel,
  input  logic             unipolar,
  input  logic             msb_first,
  input  logic [DIV_W-1:0] half_div,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             mosi_oe,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam logic [IDX_W-1:0] TAIL = IDX_W'(RES_W + 1);

  logic             busy_q, done_q;
  logic [1:0]       fmt_q;
  logic             msbf_q;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] rise_cnt, drv_len_q, skip_q;
  logic [RES_W-1:0] result_q;

  // named internal events
  logic             accept, rise_stb, fall_stb, last_fall, msbf_eff;
  logic [IDX_W-1:0] rise_num, first_num;
  logic [RES_W-1:0] rx_data;

  assign accept    = start && !busy_q;
  assign rise_num  = rise_cnt + 1'b1;
  assign first_num = skip_q + IDX_W'(2);
  assign last_fall = fall_stb && (rise_cnt == skip_q + TAIL);
  assign msbf_eff  = (fmt_q == FMT_FIXED) ? 1'b1 : msbf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      fmt_q     <= FMT_FIXED;
      msbf_q    <= 1'b0;
      div_q     <= '0;
      rise_cnt  <= '0;
      drv_len_q <= '0;
      skip_q    <= '0;
      result_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        fmt_q     <= fmt;
        msbf_q    <= msb_first;
        div_q     <= half_div;
        rise_cnt  <= '0;
        drv_len_q <= drive_len(fmt);
        skip_q    <= skip_len(fmt);
      end else if (busy_q) begin
        if (rise_stb) rise_cnt <= rise_num;
        if (last_fall) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= rx_data;
        end
      end
    end
  end

  adc_rd_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .half_div(div_q),
    .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  adc_rd_tx i_tx (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .word(build_word(fmt, sgl_end, odd_sign, chan_sel, unipolar, msb_first)),
    .len(drive_len(fmt)), .fall_stb(fall_stb), .fall_idx(rise_cnt),
    .mosi(mosi), .mosi_oe(mosi_oe)
  );

  adc_rd_rx i_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept), .rise_stb(rise_stb),
    .rise_num(rise_num), .first_num(first_num), .msbf(msbf_eff),
    .miso(miso), .data(rx_data)
  );

  assign cs_n   = !busy_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign result = result_q;

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R2
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R3
  AST_FIXED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && fmt_q == FMT_FIXED) |-> !mosi_oe); // R6
  AST_OE_CLEAR_BY_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && rise_cnt >= drv_len_q) |-> !mosi_oe); // R7
  AST_DONE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && !busy); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R10
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last_fall) |=> busy_q && $stable(fmt_q)); // R11
endmodule

// File: tb/test_adc_read_master.sv
module test_adc_read_master;
  localparam int DW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic sgl_end = 1'b0, odd_sign = 1'b0, unipolar = 1'b0, msb_first = 1'b0;
  logic [1:0] chan_sel = 2'b00;
  logic [DW-1:0] half_div = '0;
  logic cs_n, sclk, mosi, mosi_oe, busy, done;
  logic [9:0] result;
  logic miso;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  adc_read_master #(.DIV_W(DW)) i_adc_read_master (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .sgl_end(sgl_end),
    .odd_sign(odd_sign), .chan_sel(chan_sel), .unipolar(unipolar),
    .msb_first(msb_first), .half_div(half_div), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso), .busy(busy), .done(done),
    .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int s_k, s_drv, s_skip;
  logic s_oe = 1'b0, s_dout = 1'b0;
  logic [6:0] s_rx;
  logic [9:0] s_val;
  int s_kind;
  assign miso = s_dout;

  always @(negedge cs_n) begin s_k = 0; s_oe = 1'b0; s_dout = 1'b0; s_rx = '0; end
  always @(posedge cs_n) s_oe = 1'b0;
  always @(posedge sclk) if (!cs_n) begin
    s_k++;
    if (s_k <= s_drv) s_rx[s_k-1] = mosi;
  end
  always @(negedge sclk) if (!cs_n) begin
    if (s_k == s_skip) begin
      s_oe = 1'b1; s_dout = 1'b0;
    end else if (s_k > s_skip && s_k - s_skip - 1 < 10) begin
      int j;
      bit m;
      j = s_k - s_skip - 1;
      m = (s_kind == 0) ? 1'b1 : (s_kind == 1 ? s_rx[3] : s_rx[6]);
      s_dout = m ? s_val[9-j] : s_val[j];
    end
  end

  // ---------------- monitors ----------------
  int hcnt = 0;
  int exp_hd = 1;
  logic p_sclk = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && sclk) chk(0, "R2 clock idle", 1, 0);
    if (sclk && p_sclk && mosi != p_mosi) chk(0, "R3 mosi moved while sclk high", mosi, p_mosi);
    if (mosi_oe && s_oe) chk(0, "R7 line contention", 1, 0);
    if (!cs_n && s_kind == 0 && mosi_oe) chk(0, "R6 fixed part driven", 1, 0);
    if (sclk) hcnt++;
    else if (p_sclk) begin
      chk(hcnt == exp_hd, "R2 high phase", hcnt, exp_hd);
      hcnt = 0;
    end
    p_sclk = sclk;
    p_mosi = mosi;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- expected values ----------------
  function automatic logic [6:0] exp_word(input int kind, input logic s, input logic o,
                                          input logic [1:0] c, input logic u, input logic m);
    if (kind == 1) return {3'b000, m, o, s, 1'b1};      // R4
    if (kind == 2) return {m, u, c[0], c[1], o, s, 1'b1}; // R5
    return 7'd0;
  endfunction

  task automatic xfer(input logic [1:0] f, input logic s, input logic o, input logic [1:0] c,
                      input logic u, input logic m, input logic [DW-1:0] hd,
                      input logic [9:0] v, input bit poke);
    int n, frames, hde;
    s_kind = (f == 2'b00) ? 0 : (f == 2'b01 ? 1 : 2);
    s_drv  = (s_kind == 0) ? 0 : (s_kind == 1 ? 4 : 7);
    s_skip = (s_kind == 0) ? 1 : s_drv;
    s_val  = v;
    hde    = (hd == 0) ? 1 : int'(hd);
    exp_hd = hde;
    frames = s_skip + 11;
    @(negedge clk);
    fmt = f; sgl_end = s; odd_sign = o; chan_sel = c; unipolar = u; msb_first = m;
    half_div = hd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cs_n == 1'b0 && busy == 1'b1, "R1 cs low after start", cs_n, 0);
    if (s_kind != 0) chk(mosi_oe && mosi, "R3 start bit present", {mosi_oe, mosi}, 3);
    else chk(!mosi_oe, "R6 fixed part not driven", mosi_oe, 0);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) begin
        fmt = ~f; msb_first = ~m; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    chk(n == 2 * hde * frames, "R2 transfer length", n, 2 * hde * frames);
    chk(result == (s_kind == 0 ? v : v), "R8 R9 result", result, v);
    chk(cs_n == 1'b1 && busy == 1'b0, "R1 cs high with done", cs_n, 1);
    if (s_kind == 1) chk(s_rx[3:0] == exp_word(1, s, o, c, u, m)[3:0], "R4 short word", s_rx[3:0], exp_word(1, s, o, c, u, m)[3:0]);
    if (s_kind == 2) chk(s_rx == exp_word(2, s, o, c, u, m), "R5 long word", s_rx, exp_word(2, s, o, c, u, m));
    @(negedge clk);
    chk(done == 1'b0 && result == v, "R10 single done and hold", {done, result}, {1'b0, v});
    if (poke) begin
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!cs_n || done) chk(0, "R11 extra transfer", cs_n, 1);
      end
      chk(cs_n && result == v, "R11 start ignored while busy", result, v);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    s_kind = 0; s_drv = 0; s_skip = 1; s_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !mosi_oe, "R1 reset state",
        {cs_n, sclk, busy, done, mosi_oe}, 5'b10000);
    // directed corners
    xfer(2'b00, 0, 0, 2'b00, 0, 1'b0, 3'd2, 10'h2A5, 0); // R6 msb regardless
    xfer(2'b01, 1, 0, 2'b00, 0, 1'b1, 3'd1, 10'h3FF, 0); // R4 R9
    xfer(2'b01, 0, 1, 2'b00, 0, 1'b0, 3'd3, 10'h001, 0); // R9 lsb
    xfer(2'b10, 1, 1, 2'b10, 1, 1'b0, 3'd0, 10'h200, 0); // R5 R2 zero clamp
    xfer(2'b11, 0, 1, 2'b01, 0, 1'b1, 3'd7, 10'h155, 0); // R5 widest divider
    xfer(2'b10, 1, 0, 2'b11, 1, 1'b1, 3'd2, 10'h0F0, 1); // R11
    // random
    for (int t = 0; t < 40; t++) begin
      logic [31:0] r;
      r = $urandom;
      xfer(r[1:0], r[2], r[3], r[5:4], r[6], r[7], r[10:8], r[20:11], (r[23:21] == 3'd0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule